// File: doc/BRIEF.md
# Time-Interval Result Calculator for a Two-Interpolator TDC

This block converts one raw measurement record of a time-to-digital converter into a single time interval. The record has three parts. The first is the number of whole reference-clock cycles that elapsed between the two events. The second and third describe each of the two interpolators, one for the leading (START) event and one for the trailing (STOP) event. Each of these gives a coarse phase code, which names the clock sub-period where the event fell, and a fine cycle count from the vernier stage.

Each interpolator measures the time from its event to the next reference edge. That time is rebuilt from two terms:
- a calibrated coarse offset, looked up by phase code in a table that belongs to that interpolator;
- the fine count times that interpolator's own calibrated step size.

The interval is the cycle count times the clock period, plus the START time, minus the STOP time.

All arithmetic is in signed fixed point with a unit of 1/16 ps. Calibrated step sizes that are not whole picoseconds therefore keep their fraction. The datapath is a three-stage pipeline: table lookup, scaling, then combination. It accepts one record per cycle and uses valid/ready handshakes on both sides. The calibration tables and the two step sizes come in as held input vectors. They are expected to be written by surrounding logic only while the pipeline is empty.

Top module: `tdc_interval_calc`

## Requirements
- R1: With a clock period of 160000 units (10 ns), out_time equals in_cycles × 160000 + START time − STOP time, where the unit is 1/16 ps.
- R2: Each interpolator's coarse offset is the entry of its own table selected by its 4-bit phase code. Entry k occupies bits [k*TAB_W +: TAB_W] of cal_start_tab or cal_stop_tab, with TAB_W = 20. Entries may be non-uniform.
- R3: Each interpolator's fine contribution is its 7-bit fine count times its own step size (cal_start_lsb or cal_stop_lsb, 12 bits, in 1/16 ps units). This holds over the full count range 0 to 127, not just the nominal 0 to 61.
- R4: The START interpolator time is added and the STOP interpolator time is subtracted. Exchanging the two channels' inputs changes the result.
- R5: When the computed interval is below zero, out_neg is 1 and out_time is 0. When it is zero or positive, out_neg is 0 and out_time holds the value.
- R6: With out_ready held high, a record accepted on clock edge k appears on out_valid after edge k+2. in_ready stays high, so one record is taken every cycle and results leave in the order they arrived.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_time and out_neg hold their values and in_ready is 0. No result is lost or duplicated.
- R8: While rst_n is low, and right after it is released, out_valid is 0 and in_ready is 1.
- R9: The largest record gives a result in the 24-bit out_time without wrapping. That record has 15 cycles, START phase 15 with fine count 127, and a STOP time of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input record present |
| in_ready | output | 1 | Block takes the record on this edge |
| in_cycles | input | 4 | Whole reference cycles between the events |
| in_start_phase | input | 4 | START coarse phase code |
| in_start_fine | input | 7 | START vernier cycle count |
| in_stop_phase | input | 4 | STOP coarse phase code |
| in_stop_fine | input | 7 | STOP vernier cycle count |
| cal_start_tab | input | 320 | START offset table, 16 entries of 20 bits, in 1/16 ps |
| cal_stop_tab | input | 320 | STOP offset table, 16 entries of 20 bits, in 1/16 ps |
| cal_start_lsb | input | 12 | START fine step size in 1/16 ps |
| cal_stop_lsb | input | 12 | STOP fine step size in 1/16 ps |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_time | output | 24 | Interval in 1/16 ps, clamped at zero |
| out_neg | output | 1 | Interval was negative |

## Verification
The bench targets these corner cases. Each one would expose a specific defect:
- **Non-uniform tables and fractional step sizes (R2, R3).** An indexing or field-placement slip shows up as a wrong offset. A design that shares one step size between the two channels, or truncates to whole picoseconds, also gives a wrong result.
- **Results at exactly zero and below zero (R4, R5).** These catch a swapped sign, a clamp placed at the wrong threshold, and a flag that is raised without zeroing the value.
- **The all-maximum record (R9).** This exposes a sum that is too narrow and wraps.
- **Back-to-back traffic and a stalled consumer (R6, R7).** A stage that does not honour the stall would drop or repeat results. It would also let out_time change while the consumer is not ready, and the scoreboard order would break.

// File: rtl/tdc_calc_pkg.sv
package tdc_calc_pkg;
  // default widths of the measurement record and of the result
  localparam int unsigned CYC_W_D    = 4;
  localparam int unsigned PH_W_D     = 4;
  localparam int unsigned FINE_W_D   = 7;
  localparam int unsigned TAB_W_D    = 20;
  localparam int unsigned LSB_W_D    = 12;
  localparam int unsigned RES_W_D    = 24;
  // reference clock period in 1/16 ps: 10 ns * 16000
  localparam int unsigned PERIOD_Q_D = 160000;
  // interpolator channels
  localparam int unsigned NCH        = 2;
  localparam int unsigned CH_START   = 0;
  localparam int unsigned CH_STOP    = 1;
endpackage

// File: rtl/tdc_lookup_stage.sv
// Stage 1 of one channel: phase-indexed offset lookup, fine count carried along.
module tdc_lookup_stage #(
  parameter int unsigned PH_W   = 4,
  parameter int unsigned TAB_W  = 20,
  parameter int unsigned FINE_W = 7
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [PH_W-1:0]               phase,
  input  logic [FINE_W-1:0]             fine_in,
  input  logic [(1<<PH_W)*TAB_W-1:0]    table_flat,
  output logic [TAB_W-1:0]              offset_q,
  output logic [FINE_W-1:0]             fine_q
);
  localparam int unsigned NPH = 1 << PH_W;

  logic [TAB_W-1:0] entry [NPH];
  logic [TAB_W-1:0] offset_d;

  for (genvar g = 0; g < NPH; g++) begin : g_entry
    assign entry[g] = table_flat[g*TAB_W +: TAB_W];
  end

  always_comb begin
    offset_d = entry[phase];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      offset_q <= offset_d;
      fine_q   <= fine_in;
    end
  end
endmodule

// File: rtl/tdc_fine_scale.sv
// Stage 2 of one channel: offset plus fine count times calibrated step.
module tdc_fine_scale #(
  parameter int unsigned TAB_W  = 20,
  parameter int unsigned FINE_W = 7,
  parameter int unsigned LSB_W  = 12,
  parameter int unsigned CH_W   = 21
) (
  input  logic              clk,
  input  logic              en,
  input  logic [TAB_W-1:0]  offset,
  input  logic [FINE_W-1:0] fine,
  input  logic [LSB_W-1:0]  lsb,
  output logic [CH_W-1:0]   time_q
);
  logic [CH_W-1:0] prod;
  logic [CH_W-1:0] time_d;

  always_comb begin
    prod   = CH_W'(fine) * CH_W'(lsb);
    time_d = CH_W'(offset) + prod;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      time_q <= time_d;
    end
  end
endmodule

// File: rtl/tdc_interval_combine.sv
// Stage 3: base + added channel - subtracted channel, clamp below zero.
module tdc_interval_combine #(
  parameter int unsigned BASE_W = 22,
  parameter int unsigned CH_W   = 21,
  parameter int unsigned RES_W  = 24
) (
  input  logic              clk,
  input  logic              en,
  input  logic [BASE_W-1:0] base,
  input  logic [CH_W-1:0]   t_add,
  input  logic [CH_W-1:0]   t_sub,
  output logic [RES_W-1:0]  res_q,
  output logic              neg_q
);
  localparam int unsigned SUM_W = RES_W + 2;

  logic signed [SUM_W-1:0] sum_d;
  logic                    neg_d;
  logic [RES_W-1:0]        res_d;

  always_comb begin
    sum_d = SUM_W'(base) + SUM_W'(t_add) - SUM_W'(t_sub);
    neg_d = sum_d[SUM_W-1];
    res_d = neg_d ? '0 : sum_d[RES_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (en) begin
      res_q <= res_d;
      neg_q <= neg_d;
    end
  end
endmodule

// File: rtl/tdc_interval_calc.sv
module tdc_interval_calc
  import tdc_calc_pkg::*;
#(
  parameter int unsigned CYC_W    = CYC_W_D,
  parameter int unsigned PH_W     = PH_W_D,
  parameter int unsigned FINE_W   = FINE_W_D,
  parameter int unsigned TAB_W    = TAB_W_D,
  parameter int unsigned LSB_W    = LSB_W_D,
  parameter int unsigned RES_W    = RES_W_D,
  parameter int unsigned PERIOD_Q = PERIOD_Q_D
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [CYC_W-1:0]            in_cycles,
  input  logic [PH_W-1:0]             in_start_phase,
  input  logic [FINE_W-1:0]           in_start_fine,
  input  logic [PH_W-1:0]             in_stop_phase,
  input  logic [FINE_W-1:0]           in_stop_fine,
  input  logic [(1<<PH_W)*TAB_W-1:0]  cal_start_tab,
  input  logic [(1<<PH_W)*TAB_W-1:0]  cal_stop_tab,
  input  logic [LSB_W-1:0]            cal_start_lsb,
  input  logic [LSB_W-1:0]            cal_stop_lsb,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [RES_W-1:0]            out_time,
  output logic                        out_neg
);
  localparam int unsigned NPH    = 1 << PH_W;
  localparam int unsigned PROD_W = FINE_W + LSB_W;
  localparam int unsigned CH_W   = ((TAB_W > PROD_W) ? TAB_W : PROD_W) + 1;
  localparam int unsigned BASE_W = CYC_W + $clog2(PERIOD_Q + 1);

  // pipeline occupancy
  logic v_s1, v_s2, v_s3;
  logic v_s1_d, v_s2_d, v_s3_d;
  logic adv;

  // shared stage data
  logic [CYC_W-1:0]  cyc_s1;
  logic [BASE_W-1:0] base_d, base_s2;

  // per-channel views
  logic [PH_W-1:0]        ph_in   [NCH];
  logic [FINE_W-1:0]      fine_in [NCH];
  logic [NPH*TAB_W-1:0]   tab_in  [NCH];
  logic [LSB_W-1:0]       lsb_in  [NCH];
  logic [TAB_W-1:0]       off_s1  [NCH];
  logic [FINE_W-1:0]      fine_s1 [NCH];
  logic [CH_W-1:0]        t_s2    [NCH];

  assign ph_in[CH_START]   = in_start_phase;
  assign ph_in[CH_STOP]    = in_stop_phase;
  assign fine_in[CH_START] = in_start_fine;
  assign fine_in[CH_STOP]  = in_stop_fine;
  assign tab_in[CH_START]  = cal_start_tab;
  assign tab_in[CH_STOP]   = cal_stop_tab;
  assign lsb_in[CH_START]  = cal_start_lsb;
  assign lsb_in[CH_STOP]   = cal_stop_lsb;

  // whole pipeline moves when the output slot is free or being drained
  always_comb begin
    adv      = !v_s3 || out_ready;
    in_ready = adv;
    v_s1_d   = in_valid;
    v_s2_d   = v_s1;
    v_s3_d   = v_s2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_s1 <= 1'b0;
      v_s2 <= 1'b0;
      v_s3 <= 1'b0;
    end else if (adv) begin
      v_s1 <= v_s1_d;
      v_s2 <= v_s2_d;
      v_s3 <= v_s3_d;
    end
  end

  assign out_valid = v_s3;

  // stage 1: cycle count capture
  always_ff @(posedge clk) begin
    if (adv) begin
      cyc_s1 <= in_cycles;
    end
  end

  // stage 2: cycle count scaled by the clock period
  always_comb begin
    base_d = BASE_W'(cyc_s1) * BASE_W'(PERIOD_Q);
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      base_s2 <= base_d;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    tdc_lookup_stage #(
      .PH_W   (PH_W),
      .TAB_W  (TAB_W),
      .FINE_W (FINE_W)
    ) u_lookup (
      .clk        (clk),
      .en         (adv),
      .phase      (ph_in[ch]),
      .fine_in    (fine_in[ch]),
      .table_flat (tab_in[ch]),
      .offset_q   (off_s1[ch]),
      .fine_q     (fine_s1[ch])
    );

    tdc_fine_scale #(
      .TAB_W  (TAB_W),
      .FINE_W (FINE_W),
      .LSB_W  (LSB_W),
      .CH_W   (CH_W)
    ) u_scale (
      .clk    (clk),
      .en     (adv),
      .offset (off_s1[ch]),
      .fine   (fine_s1[ch]),
      .lsb    (lsb_in[ch]),
      .time_q (t_s2[ch])
    );
  end

  // stage 3: START added, STOP subtracted
  tdc_interval_combine #(
    .BASE_W (BASE_W),
    .CH_W   (CH_W),
    .RES_W  (RES_W)
  ) u_combine (
    .clk   (clk),
    .en    (adv),
    .base  (base_s2),
    .t_add (t_s2[CH_START]),
    .t_sub (t_s2[CH_STOP]),
    .res_q (out_time),
    .neg_q (out_neg)
  );
endmodule

// File: rtl/tdc_interval_calc_chk.sv
module tdc_interval_calc_chk #(
  parameter int unsigned RES_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [RES_W-1:0] out_time,
  input logic             out_neg
);
  logic [2:0] inflight, inflight_d;

  always_comb begin
    inflight_d = inflight + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight_d;
  end

  // R8
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_idle_chk: assert (!out_valid && in_ready);
    end
  end

  // R5
  neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_neg) |-> (out_time == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_time) && $stable(out_neg)));

  // R7
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd3);
endmodule

bind tdc_interval_calc tdc_interval_calc_chk #(.RES_W(RES_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_time  (out_time),
  .out_neg   (out_neg)
);

// File: tb/tdc_interval_calc_bench.sv
module tdc_interval_calc_bench;
  localparam int TAB_W  = 20;
  localparam int LSB_W  = 12;
  localparam int RES_W  = 24;
  localparam int PERIOD = 160000;
  localparam int NPH    = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic                   in_valid, in_ready, out_valid, out_ready, out_neg;
  logic [3:0]             in_cycles, in_start_phase, in_stop_phase;
  logic [6:0]             in_start_fine, in_stop_fine;
  logic [NPH*TAB_W-1:0]   cal_start_tab, cal_stop_tab;
  logic [LSB_W-1:0]       cal_start_lsb, cal_stop_lsb;
  logic [RES_W-1:0]       out_time;

  tdc_interval_calc u_tdc_interval_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cycles(in_cycles), .in_start_phase(in_start_phase), .in_start_fine(in_start_fine),
    .in_stop_phase(in_stop_phase), .in_stop_fine(in_stop_fine),
    .cal_start_tab(cal_start_tab), .cal_stop_tab(cal_stop_tab),
    .cal_start_lsb(cal_start_lsb), .cal_stop_lsb(cal_stop_lsb),
    .out_valid(out_valid), .out_ready(out_ready), .out_time(out_time), .out_neg(out_neg)
  );

  typedef struct {
    longint val;
    bit     neg;
    string  req;
    bit     lat;
    int     issue;
  } exp_t;

  exp_t   sb [$];
  int     checks = 0;
  int     errors = 0;
  int     cyc_cnt = 0;
  int     waited = 0;
  longint tab_s [NPH];
  longint tab_t [NPH];
  longint lsb_s, lsb_t;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_cal();
    for (int i = 0; i < NPH; i++) begin
      cal_start_tab[i*TAB_W +: TAB_W] = TAB_W'(tab_s[i]);
      cal_stop_tab[i*TAB_W +: TAB_W]  = TAB_W'(tab_t[i]);
    end
    cal_start_lsb = LSB_W'(lsb_s);
    cal_stop_lsb  = LSB_W'(lsb_t);
  endtask

  task automatic send(input int c, input int sp, input int sf, input int tp, input int tf,
                      input string req, input bit lat);
    longint e;
    exp_t   it;
    e = longint'(c) * PERIOD + tab_s[sp] + longint'(sf) * lsb_s - tab_t[tp] - longint'(tf) * lsb_t;
    @(negedge clk);
    in_valid       = 1'b1;
    in_cycles      = 4'(c);
    in_start_phase = 4'(sp);
    in_start_fine  = 7'(sf);
    in_stop_phase  = 4'(tp);
    in_stop_fine   = 7'(tf);
    #1;
    while (!in_ready) begin
      waited++;
      @(negedge clk);
      #1;
    end
    it.neg   = (e < 0);
    it.val   = (e < 0) ? 0 : e;
    it.req   = req;
    it.lat   = lat;
    it.issue = cyc_cnt;
    sb.push_back(it);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7", "unexpected result", longint'(out_time), -1);
        end else begin
          it = sb.pop_front();
          check(out_time == RES_W'(it.val), it.req, "out_time", longint'(out_time), it.val);
          check(out_neg == it.neg, it.req, "out_neg", longint'(out_neg), longint'(it.neg));
          if (it.lat) check(cyc_cnt - it.issue == 3, "R6", "latency", cyc_cnt - it.issue, 3);
        end
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [RES_W-1:0] held;
    rst_n = 1'b0;
    in_valid = 1'b0; out_ready = 1'b1;
    in_cycles = '0; in_start_phase = '0; in_start_fine = '0;
    in_stop_phase = '0; in_stop_fine = '0;
    for (int i = 0; i < NPH; i++) begin
      tab_s[i] = i * 10000;
      tab_t[i] = i * 10000;
    end
    lsb_s = 160; lsb_t = 160;
    apply_cal();
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8", "out_valid in reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R8", "in_ready in reset", longint'(in_ready), 1);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", longint'(in_ready), 1);

    // R1 nominal calibration, plus an isolated latency probe for R6
    send(3, 5, 20, 2, 7, "R1", 1'b1);
    drain();
    send(0, 8, 0, 3, 0, "R4", 1'b0);
    send(0, 3, 0, 8, 0, "R4", 1'b0);
    send(0, 6, 9, 6, 9, "R5", 1'b0);
    send(0, 0, 0, 15, 61, "R5", 1'b0);
    send(15, 15, 127, 0, 0, "R9", 1'b0);
    drain();

    // R2 non-uniform tables
    for (int i = 0; i < NPH; i++) begin
      tab_s[i] = i * 10000 + (i * i * 37) % 500;
      tab_t[i] = i * 10000 + i * 13;
    end
    apply_cal();
    send(2, 7, 11, 11, 4, "R2", 1'b0);
    send(1, 13, 0, 1, 0, "R2", 1'b0);
    drain();

    // R3 distinct fractional step sizes, full fine range
    lsb_s = 163; lsb_t = 402;
    apply_cal();
    send(4, 2, 127, 9, 127, "R3", 1'b0);
    send(0, 0, 127, 0, 1, "R3", 1'b0);
    drain();

    // R6 back-to-back traffic
    waited = 0;
    for (int k = 0; k < 8; k++) send(k, k, k * 15, 15 - k, k * 3, "R6", 1'b0);
    check(waited == 0, "R6", "in_ready dropped during burst", waited, 0);
    drain();

    // R7 stalled consumer
    @(negedge clk) out_ready = 1'b0;
    send(5, 1, 10, 2, 20, "R7", 1'b0);
    send(6, 3, 30, 4, 40, "R7", 1'b0);
    send(0, 0, 0, 9, 9, "R7", 1'b0);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R7", "out_valid while stalled", longint'(out_valid), 1);
    check(in_ready == 1'b0, "R7", "in_ready while stalled", longint'(in_ready), 0);
    held = out_time;
    repeat (3) @(negedge clk);
    #1;
    check(out_time == held, "R7", "out_time held", longint'(out_time), longint'(held));
    check(out_valid == 1'b1, "R7", "out_valid held", longint'(out_valid), 1);
    @(negedge clk) out_ready = 1'b1;
    drain();
    check(sb.size() == 0, "R7", "results outstanding", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule